// File: doc/BRIEF.md
# Alternating-Edge Byte Deserializer

This block sits behind a start-pattern detector on a two-wire bus where neither wire is a dedicated clock. The two wires take turns: a falling edge on wire A captures the level of wire B as the next bit, then a falling edge on wire B captures the level of wire A, and so on. Once the detector pulses `frame_go`, the block follows this alternation. It shifts bits into a byte, most significant bit first, and hands each finished byte out with a one-cycle strobe.

The frame ends with an in-band marker. Wire A falls twice in a row while wire B stays low, and both wires then rise. The block recognises this marker partway through what would otherwise be the first bit pair of a byte. Any edge that breaks the strict alternation aborts the frame with an error strobe. After an end or an error the block goes idle and ignores the wires until the next `frame_go`. Wire levels must already be synchronised to `clk`.

Top module: `aed_deserializer`

## Requirements
- R1: After reset all three strobes are low, and the block is idle. While idle, edges on either wire produce no strobe. Only `frame_go` starts reception.
- R2: A wire-A fall while the A-edge and B-edge counts of the current byte are equal takes the level of wire B as the next bit.
- R3: A wire-B fall while the A-edge count is one above the B-edge count takes the level of wire A as the next bit. Bits enter MSB first, so the first bit of a byte lands in `byte_data[7]`. A byte is complete after its fourth accepted B-fall (eight bits).
- R4: After a byte completes, the block waits until wire A is high. On the next cycle `byte_valid` is high for exactly one cycle, with the byte on `byte_data`. `byte_data` changes only on such a cycle.
- R5: Before any bit of a byte has been taken, one wire-B fall with wire A high is accepted and ignored. A second such fall in the same byte is a frame error.
- R6: A second wire-A fall with wire B low is the end marker. It is recognised only when it follows exactly one A-fall that took a 0 and no B-fall in the current byte. Once both wires are high after that, `end_of_frame` pulses for one cycle and the block returns to idle.
- R7: If either wire falls while the block waits for both wires to go high after the end marker, `frame_error` pulses and the block goes idle.
- R8: Any other edge that breaks the alternation order pulses `frame_error` for one cycle and returns the block to idle. At most one of the three strobes is high in any cycle.
- R9: Falls on both wires in the same cycle during bit collection are a frame error.
- R10: While the block waits for wire A to rise after a complete byte, wire-B falls are ignored. The byte delivered is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_go | input | 1 | Start-pattern detector pulse: a frame body follows |
| line_a | input | 1 | Synchronised level of wire A |
| line_b | input | 1 | Synchronised level of wire B |
| byte_valid | output | 1 | One-cycle strobe: `byte_data` holds a new byte |
| byte_data | output | 8 | Last completed byte, MSB received first |
| end_of_frame | output | 1 | One-cycle strobe: end marker completed |
| frame_error | output | 1 | One-cycle strobe: alternation or end-marker violation |

## Verification
The embedded properties assume that `line_a` and `line_b` are already synchronous to `clk`, with no metastable or glitching levels. They also assume that `frame_go` is raised only while the block is idle, with both wires high. The stimulus changes the wires only at falling clock edges and holds each level for at least two clock cycles. It pulses `frame_go` only after the wires have been returned high, so every fall is seen as a single clean edge.

// File: rtl/aed_pkg.sv
package aed_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BITS  = 2'd1,
        ST_AHIGH = 2'd2,
        ST_ENDW  = 2'd3
    } aed_state_e;

    typedef struct packed {
        logic a_fall;
        logic b_fall;
        logic a_lvl;
        logic b_lvl;
    } aed_lines_t;

    function automatic logic aed_both_high(aed_lines_t l);
        return l.a_lvl & l.b_lvl;
    endfunction

    function automatic logic aed_any_fall(aed_lines_t l);
        return l.a_fall | l.b_fall;
    endfunction

endpackage

// File: rtl/aed_edge.sv
module aed_edge
    import aed_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_a,
    input  logic       line_b,
    output aed_lines_t lines
);
    logic prev_a;
    logic prev_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b1;
            prev_b <= 1'b1;
        end else begin
            prev_a <= line_a;
            prev_b <= line_b;
        end
    end

    always_comb begin
        lines.a_fall = prev_a & ~line_a;
        lines.b_fall = prev_b & ~line_b;
        lines.a_lvl  = line_a;
        lines.b_lvl  = line_b;
    end

endmodule

// File: rtl/aed_shifter.sv
module aed_shifter #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 bit_in,
    input  logic                 load,
    output logic                 acc_zero,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data
);
    logic [BYTE_BITS-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= load;
            if (load) begin
                byte_data <= acc;
            end
            if (clear) begin
                acc <= '0;
            end else if (shift_en) begin
                acc <= {acc[BYTE_BITS-2:0], bit_in};
            end
        end
    end

    assign acc_zero = (acc == '0);

    // R4: published byte only moves on a load
    a_r4_byte_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(byte_data));

endmodule

// File: rtl/aed_seq.sv
module aed_seq
    import aed_pkg::*;
#(
    parameter int PAIRS = 4,
    parameter int CW    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_go,
    input  aed_lines_t lines,
    input  logic       acc_zero,
    output logic       clear,
    output logic       shift_en,
    output logic       bit_in,
    output logic       load,
    output logic       end_of_frame,
    output logic       frame_error
);
    localparam logic [CW-1:0] LAST = CW'(PAIRS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    aed_state_e    st, st_n;
    logic [CW-1:0] ca, ca_n, cb, cb_n;
    logic          first, first_n;
    logic          ev_end, ev_err;

    always_comb begin
        st_n     = st;
        ca_n     = ca;
        cb_n     = cb;
        first_n  = first;
        clear    = 1'b0;
        shift_en = 1'b0;
        bit_in   = 1'b0;
        load     = 1'b0;
        ev_end   = 1'b0;
        ev_err   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (frame_go) begin
                    st_n    = ST_BITS;
                    clear   = 1'b1;
                    ca_n    = '0;
                    cb_n    = '0;
                    first_n = 1'b1;
                end
            end
            ST_BITS: begin
                if (lines.a_fall && lines.b_fall) begin
                    ev_err = 1'b1;
                end else if (lines.a_fall) begin
                    if (ca == cb) begin
                        shift_en = 1'b1;
                        bit_in   = lines.b_lvl;
                        ca_n     = ca + 1'b1;
                    end else if (ca == ONE && cb == '0 && acc_zero && !lines.b_lvl) begin
                        st_n = ST_ENDW;
                    end else begin
                        ev_err = 1'b1;
                    end
                end else if (lines.b_fall) begin
                    if (ca == cb + 1'b1) begin
                        shift_en = 1'b1;
                        bit_in   = lines.a_lvl;
                        cb_n     = cb + 1'b1;
                        if (cb + 1'b1 == LAST) begin
                            st_n = ST_AHIGH;
                        end
                    end else if (ca == '0 && cb == '0 && lines.a_lvl && first) begin
                        first_n = 1'b0;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
            end
            ST_AHIGH: begin
                if (lines.a_lvl) begin
                    load    = 1'b1;
                    clear   = 1'b1;
                    st_n    = ST_BITS;
                    ca_n    = '0;
                    cb_n    = '0;
                    first_n = 1'b1;
                end
            end
            ST_ENDW: begin
                if (aed_any_fall(lines)) begin
                    ev_err = 1'b1;
                end else if (aed_both_high(lines)) begin
                    ev_end = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (ev_err) begin
            st_n = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            ca           <= '0;
            cb           <= '0;
            first        <= 1'b1;
            end_of_frame <= 1'b0;
            frame_error  <= 1'b0;
        end else begin
            st           <= st_n;
            ca           <= ca_n;
            cb           <= cb_n;
            first        <= first_n;
            end_of_frame <= ev_end;
            frame_error  <= ev_err;
        end
    end

    // R2: during collection the A count leads the B count by zero or one
    a_r2_edge_order: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BITS) |-> (ca == cb || ca == cb + 1'b1));
    // R3: no more than PAIRS B-samples per byte
    a_r3_cb_limit: assert property (@(posedge clk) disable iff (rst)
        cb <= LAST);
    // R6: an end strobe leaves the block idle
    a_r6_idle_after_end: assert property (@(posedge clk) disable iff (rst)
        end_of_frame |-> st == ST_IDLE);
    // R8: an error strobe leaves the block idle
    a_r8_idle_after_error: assert property (@(posedge clk) disable iff (rst)
        frame_error |-> st == ST_IDLE);

endmodule

// File: rtl/aed_deserializer.sv
module aed_deserializer
    import aed_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_go,
    input  logic                 line_a,
    input  logic                 line_b,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data,
    output logic                 end_of_frame,
    output logic                 frame_error
);
    localparam int PAIRS = BYTE_BITS / 2;
    localparam int CW    = $clog2(PAIRS + 1);

    aed_lines_t lines;
    logic       clear, shift_en, bit_in, load, acc_zero;

    aed_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_a (line_a),
        .line_b (line_b),
        .lines  (lines)
    );

    aed_seq #(.PAIRS(PAIRS), .CW(CW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .frame_go     (frame_go),
        .lines        (lines),
        .acc_zero     (acc_zero),
        .clear        (clear),
        .shift_en     (shift_en),
        .bit_in       (bit_in),
        .load         (load),
        .end_of_frame (end_of_frame),
        .frame_error  (frame_error)
    );

    aed_shifter #(.BYTE_BITS(BYTE_BITS)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .shift_en   (shift_en),
        .bit_in     (bit_in),
        .load       (load),
        .acc_zero   (acc_zero),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    // R4: byte strobe lasts one cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);
    // R8: strobes are mutually exclusive
    a_r8_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_valid, end_of_frame, frame_error}));

endmodule

// File: tb/sim_aed_deserializer.sv
`timescale 1ns/100ps
module sim_aed_deserializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_go = 1'b0;
    logic       la = 1'b1;
    logic       lb = 1'b1;
    logic       byte_valid, end_of_frame, frame_error;
    logic [7:0] byte_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    aed_deserializer u0 (
        .clk(clk), .rst(rst), .frame_go(frame_go),
        .line_a(la), .line_b(lb),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .end_of_frame(end_of_frame), .frame_error(frame_error)
    );

    // behavioural reference: mode 0 idle, 1 collect, 2 wait A high, 3 end wait
    int mode = 0, na = 0, nb = 0, acc = 0, pa = 1, pb = 1;
    bit once = 1;
    bit e_v = 0, e_end = 0, e_err = 0;
    int e_byte = 0;

    always @(posedge clk) begin
        bit fa, fb, bad;
        fa = (pa == 1) && !la;
        fb = (pb == 1) && !lb;
        e_v = 0; e_end = 0; bad = 0;
        if (rst) begin
            mode = 0; pa = 1; pb = 1; e_err = 0; e_byte = 0;
        end else begin
            if (mode == 0) begin
                if (frame_go) begin mode = 1; na = 0; nb = 0; acc = 0; once = 1; end
            end else if (mode == 1) begin
                if (fa && fb) bad = 1;
                else if (fa) begin
                    if (na == nb) begin acc = ((acc << 1) | int'(lb)) & 255; na++; end
                    else if (na == 1 && nb == 0 && acc == 0 && !lb) mode = 3;
                    else bad = 1;
                end else if (fb) begin
                    if (na == nb + 1) begin
                        acc = ((acc << 1) | int'(la)) & 255; nb++;
                        if (nb == 4) mode = 2;
                    end else if (na == 0 && nb == 0 && la && once) once = 0;
                    else bad = 1;
                end
            end else if (mode == 2) begin
                if (la) begin
                    e_v = 1; e_byte = acc; mode = 1; na = 0; nb = 0; acc = 0; once = 1;
                end
            end else begin
                if (fa || fb) bad = 1;
                else if (la && lb) begin e_end = 1; mode = 0; end
            end
            if (bad) mode = 0;
            e_err = bad;
            pa = int'(la); pb = int'(lb);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [7:0] got[$];
    int n_end = 0, n_err = 0;

    always @(posedge clk) begin
        #1;
        chk(byte_valid == e_v, "R4 byte_valid", int'(byte_valid), int'(e_v));
        if (e_v) chk(byte_data == 8'(e_byte), "R3 byte_data", int'(byte_data), e_byte);
        chk(end_of_frame == e_end, "R6 end_of_frame", int'(end_of_frame), int'(e_end));
        chk(frame_error == e_err, "R8 frame_error", int'(frame_error), int'(e_err));
        if (byte_valid) got.push_back(byte_data);
        if (end_of_frame) n_end++;
        if (frame_error) n_err++;
    end

    task automatic set_lines(input logic a, input logic b);
        @(negedge clk); la = a; lb = b;
        @(negedge clk);
    endtask

    task automatic go();
        @(negedge clk); frame_go = 1'b1;
        @(negedge clk); frame_go = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit hold);
        for (int i = 0; i < 4; i++) begin
            set_lines(1'b1, v[7-2*i]);
            set_lines(1'b0, v[7-2*i]);
            set_lines(v[6-2*i], 1'b1);
            set_lines(v[6-2*i], 1'b0);
            if (i == 3 && hold) begin
                set_lines(1'b0, 1'b1);
                set_lines(1'b0, 1'b0);
            end
            set_lines(1'b1, 1'b0);
        end
    endtask

    task automatic end_mark();
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b0);
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b1);
    endtask

    task automatic expect_counts(input string tag, input int nbytes, input int ne, input int nr);
        repeat (3) @(negedge clk);
        chk(got.size() == nbytes, {tag, " byte count"}, got.size(), nbytes);
        chk(n_end == ne, {tag, " end count"}, n_end, ne);
        chk(n_err == nr, {tag, " error count"}, n_err, nr);
    endtask

    task automatic clear_counts();
        got.delete(); n_end = 0; n_err = 0;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!byte_valid && !end_of_frame && !frame_error, "R1 reset strobes", 0, 0);
        rst = 1'b0;

        // R1: edges while idle do nothing
        send_byte(8'hC3, 1'b0);
        set_lines(1'b1, 1'b1);
        expect_counts("R1 idle", 0, 0, 0);

        // R2 R3 R4 R10: three bytes, the last with B toggling while A waits low
        clear_counts();
        go();
        send_byte(8'hA5, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h5A, 1'b1);
        end_mark();
        expect_counts("R6 frame one", 3, 1, 0);
        if (got.size() == 3) begin
            chk(got[0] == 8'hA5, "R2 byte0", got[0], 8'hA5);
            chk(got[1] == 8'h3C, "R3 byte1", got[1], 8'h3C);
            chk(got[2] == 8'h5A, "R10 byte2", got[2], 8'h5A);
        end

        // R5: leading B fall with A high ignored once; R6 idle after end
        clear_counts();
        go();
        send_byte(8'h5A, 1'b0);
        send_byte(8'h00, 1'b0);
        end_mark();
        send_byte(8'h77, 1'b0);
        set_lines(1'b1, 1'b1);
        expect_counts("R5 frame two", 2, 1, 0);
        if (got.size() == 2) begin
            chk(got[0] == 8'h5A, "R5 byte0", got[0], 8'h5A);
            chk(got[1] == 8'h00, "R3 zero byte", got[1], 8'h00);
        end

        // R7: fall during end wait
        clear_counts();
        go();
        send_byte(8'h81, 1'b0);
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b0);
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b0);
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b1);
        expect_counts("R7 end wait fall", 1, 0, 1);

        // R8: second A fall after a 1 bit, then idle edges ignored
        clear_counts();
        go();
        set_lines(1'b0, 1'b1);
        set_lines(1'b1, 1'b1);
        set_lines(1'b0, 1'b1);
        send_byte(8'hFF, 1'b0);
        set_lines(1'b1, 1'b1);
        expect_counts("R8 order break", 0, 0, 1);

        // R5: a second leading B fall is an error
        clear_counts();
        go();
        set_lines(1'b1, 1'b0);
        set_lines(1'b1, 1'b1);
        set_lines(1'b1, 1'b0);
        set_lines(1'b1, 1'b1);
        expect_counts("R5 second lead fall", 0, 0, 1);

        // R9: both wires fall together
        clear_counts();
        go();
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b1);
        expect_counts("R9 joint fall", 0, 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule